// File: doc/BRIEF.md
# Eight-Pin I/O Port with Memory-Bus Takeover

This block is one general-purpose I/O port of eight pins. Software sets each pin's direction and its output level (or, for an input pin, its pull-up) through a small register bus. It reads the pin levels back after they pass through a synchronizer. A control register holds a global switch that turns off every pull-up. It also holds three plain storage bits that other logic uses.

When the external memory interface is enabled, it takes over all eight pins at once. The low address byte and the data byte then share the pins. An address strobe puts address bits on the pins, and a write strobe puts data bits on them. With neither strobe high, the pins float as inputs. The port's output-level bit then acts as a bus-hold pull-up, so the bus keeps its level while it is idle and during reads. The synchronized pin value is always offered to the memory interface as its read-data byte.

The pins are modelled as separate output-value, output-enable and pull-up-enable vectors plus an input vector. A combinational phase decoder picks one of five named phases:
- `PH_GPIO`: the memory interface is off.
- `PH_HOLD`: takeover with no strobe.
- `PH_ADDR`: address strobe only.
- `PH_WRITE`: write strobe only.
- `PH_ADDR_WRITE`: both strobes.

The phase follows the strobes in the same cycle, with no stored transitions. The only sequential paths are the registers and the synchronizer stages.

Top module: `gpio_busmux_port`

## Requirements
- R1: While `rst_n` is low, `pad_oe` and `pad_pu` are all zero even if `xm_en` is high. After reset, the direction, output-level and control registers read 0, and `xm_rdata` is 0.
- R2: Register address 0 holds the direction byte (1 = output) and address 1 holds the output-level byte. A write with `reg_we` high is visible on `reg_rdata` after the next rising clock edge. Reads are combinational from `reg_addr`.
- R3: Address 3 is the control register. Bits 7, 4, 1 and 0 are writable. Bits 6, 5, 3 and 2 always read 0 and ignore writes. Bit 4 is the global pull-up-off switch.
- R4: Address 2 returns the synchronized pin byte. Writes to address 2 change no register.
- R5: With `xm_en` low, `pad_oe` equals the direction byte and `pad_out` equals the output-level byte.
- R6: With `xm_en` low, a pin's pull-up is on when its direction bit is 0, its output-level bit is 1 and control bit 4 is 0.
- R7: With control bit 4 set, `pad_pu` is all zero in every phase.
- R8: With `xm_en` high, every pin is an output when `xm_wr` or `xm_ale` is high, and every pin is an input otherwise, whatever the direction byte holds.
- R9: With `xm_en` high, `pad_out` = (`xm_addr` AND `xm_ale`) OR (`xm_wdata` AND `xm_wr`), bit by bit.
- R10: With `xm_en` high, a pin's pull-up is on only when both strobes are low, its output-level bit is 1 and control bit 4 is 0. No pin ever has its pull-up and its output enable on together.
- R11: A value on `pad_in` appears at address 2 and on `xm_rdata` after exactly two rising clock edges, in every phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| xm_en | input | 1 | Memory interface takes over the pins |
| xm_wr | input | 1 | Memory write strobe |
| xm_ale | input | 1 | Memory address-phase strobe |
| xm_addr | input | 8 | Low address byte |
| xm_wdata | input | 8 | Memory write data byte |
| xm_rdata | output | 8 | Synchronized pin byte to the memory interface |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| pad_pu | output | 8 | Pin pull-up enables |

## Verification
The bench builds the port with its default parameters: eight pins and a two-stage synchronizer. With eight pins, eight computed direction and output-level patterns give every pin both values of each register bit. The 16 combinations of pull-up-off, takeover and the two strobes are then swept fully over each pattern. The two-stage depth makes the exact input latency observable edge by edge, both at the read-back address and on the memory read-data byte.

// File: rtl/gpio_busmux_pkg.sv
package gpio_busmux_pkg;
    localparam int PORT_W      = 8;
    localparam int REG_AW      = 2;
    localparam int SYNC_DEPTH  = 2;
    localparam int PUOFF_BIT   = 4;
    localparam logic [7:0] CTRL_WMASK = 8'b1001_0011;

    typedef enum logic [1:0] {
        RA_DIR   = 2'd0,
        RA_LEVEL = 2'd1,
        RA_PINS  = 2'd2,
        RA_CTRL  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        PH_GPIO       = 3'd0,
        PH_HOLD       = 3'd1,
        PH_ADDR       = 3'd2,
        PH_WRITE      = 3'd3,
        PH_ADDR_WRITE = 3'd4
    } bus_phase_e;
endpackage

// File: rtl/gpio_busmux_regs.sv
module gpio_busmux_regs
    import gpio_busmux_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [W-1:0]  reg_wdata,
    input  logic [W-1:0]  pins_sync,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  level_q,
    output logic          pu_off,
    output logic [W-1:0]  reg_rdata
);
    localparam logic [W-1:0] WMASK = W'(CTRL_WMASK);

    logic [W-1:0] ctrl_q;
    reg_sel_e     sel;

    assign sel    = reg_sel_e'(reg_addr);
    assign pu_off = ctrl_q[PUOFF_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            level_q <= '0;
            ctrl_q  <= '0;
        end else if (reg_we) begin
            unique case (sel)
                RA_DIR:   dir_q   <= reg_wdata;
                RA_LEVEL: level_q <= reg_wdata;
                RA_PINS:  ;
                RA_CTRL:  ctrl_q  <= reg_wdata & WMASK;
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RA_DIR:   reg_rdata = dir_q;
            RA_LEVEL: reg_rdata = level_q;
            RA_PINS:  reg_rdata = pins_sync;
            RA_CTRL:  reg_rdata = ctrl_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: a direction write lands on the next edge
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel == RA_DIR) |=> (dir_q == $past(reg_wdata)));

    // R4: writes to the pin address leave all storage untouched
    assert_pins_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel == RA_PINS) |=> ($stable(dir_q) && $stable(level_q) && $stable(ctrl_q)));
endmodule

// File: rtl/gpio_busmux_sync.sv
module gpio_busmux_sync
    import gpio_busmux_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= din;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st[g] <= '0;
                else        st[g] <= st[g-1];
            end
        end
    endgenerate

    assign dout = st[STAGES-1];

    // edges seen since reset, saturating; lets the latency check start safely
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            assert_sync_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (age >= 2'd2) |-> (dout == $past(din, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_busmux_pads.sv
module gpio_busmux_pads
    import gpio_busmux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         takeover,
    input  logic         xm_wr,
    input  logic         xm_ale,
    input  logic [W-1:0] xm_addr,
    input  logic [W-1:0] xm_wdata,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] level_q,
    input  logic         pu_off,
    output bus_phase_e   phase,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    always_comb begin
        phase = PH_GPIO;
        if (takeover) begin
            unique case ({xm_ale, xm_wr})
                2'b00:   phase = PH_HOLD;
                2'b10:   phase = PH_ADDR;
                2'b01:   phase = PH_WRITE;
                2'b11:   phase = PH_ADDR_WRITE;
                default: phase = PH_HOLD;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            always_comb begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
                pad_pu[i]  = 1'b0;
                unique case (phase)
                    PH_GPIO: begin
                        pad_oe[i]  = dir_q[i];
                        pad_out[i] = level_q[i];
                        pad_pu[i]  = ~dir_q[i] & level_q[i] & ~pu_off;
                    end
                    PH_HOLD: begin
                        pad_pu[i]  = level_q[i] & ~pu_off;
                    end
                    PH_ADDR: begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = xm_addr[i];
                    end
                    PH_WRITE: begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = xm_wdata[i];
                    end
                    PH_ADDR_WRITE: begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = xm_addr[i] | xm_wdata[i];
                    end
                    default: ;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_busmux_port.sv
module gpio_busmux_port
    import gpio_busmux_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [PORT_W-1:0]   reg_wdata,
    output logic [PORT_W-1:0]   reg_rdata,
    input  logic                xm_en,
    input  logic                xm_wr,
    input  logic                xm_ale,
    input  logic [PORT_W-1:0]   xm_addr,
    input  logic [PORT_W-1:0]   xm_wdata,
    output logic [PORT_W-1:0]   xm_rdata,
    input  logic [PORT_W-1:0]   pad_in,
    output logic [PORT_W-1:0]   pad_out,
    output logic [PORT_W-1:0]   pad_oe,
    output logic [PORT_W-1:0]   pad_pu
);
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] level_q;
    logic              pu_off;
    logic              takeover;
    bus_phase_e        phase;

    // the memory interface counts as off while reset is held
    assign takeover = xm_en & rst_n;
    assign xm_rdata = pins_sync;

    gpio_busmux_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pins_sync)
    );

    gpio_busmux_regs #(.W(PORT_W), .AW(REG_AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .pins_sync(pins_sync),
        .dir_q    (dir_q),
        .level_q  (level_q),
        .pu_off   (pu_off),
        .reg_rdata(reg_rdata)
    );

    gpio_busmux_pads #(.W(PORT_W)) u_pads (
        .takeover(takeover),
        .xm_wr   (xm_wr),
        .xm_ale  (xm_ale),
        .xm_addr (xm_addr),
        .xm_wdata(xm_wdata),
        .dir_q   (dir_q),
        .level_q (level_q),
        .pu_off  (pu_off),
        .phase   (phase),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // R7: the global switch silences every pull-up
    assert_pu_off_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pu_off |-> (pad_pu == '0));

    // R10: a pin never pulls up while it drives
    assert_pu_oe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    // R8: under takeover a strobe makes every pin drive
    assert_takeover_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_en && (xm_wr || xm_ale)) |-> (pad_oe == '1));

    // R8: under takeover without a strobe every pin floats
    assert_takeover_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_en && !xm_wr && !xm_ale) |-> (pad_oe == '0));

    // R5: outside takeover the enables follow the direction register
    assert_gpio_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_GPIO) |-> (pad_oe == dir_q));

    // R1: nothing drives or pulls up while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (pad_oe == '0 && pad_pu == '0);
        end
    end
endmodule

// File: tb/gpio_busmux_port_tb.sv
module gpio_busmux_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       xm_en = 1'b0, xm_wr = 1'b0, xm_ale = 1'b0;
    logic [7:0] xm_addr = '0, xm_wdata = '0, xm_rdata;
    logic [7:0] pad_in = '0, pad_out, pad_oe, pad_pu;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gpio_busmux_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xm_en(xm_en), .xm_wr(xm_wr), .xm_ale(xm_ale),
        .xm_addr(xm_addr), .xm_wdata(xm_wdata), .xm_rdata(xm_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, "readback", reg_rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] dv, pv, av, wv, e_oe, e_out, e_pu;
        logic pud, en, w, ale;

        // R1: reset holds pins quiet even with takeover requested
        xm_en = 1'b1; xm_wr = 1'b1; pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        #0.5;
        chk("R1", "oe in reset", pad_oe, 8'h00);
        chk("R1", "pu in reset", pad_pu, 8'h00);
        chk("R1", "rdata in reset", xm_rdata, 8'h00);
        rst_n = 1'b1; xm_en = 1'b0; xm_wr = 1'b0; pad_in = 8'h00;
        #0.5;
        rd_chk("R1", 2'd0, 8'h00);
        rd_chk("R1", 2'd1, 8'h00);
        rd_chk("R1", 2'd3, 8'h00);

        // R2: direction and level registers
        wr_reg(2'd0, 8'hA5); rd_chk("R2", 2'd0, 8'hA5);
        wr_reg(2'd1, 8'h3C); rd_chk("R2", 2'd1, 8'h3C);

        // R3: control mask and pull-up-off bit
        wr_reg(2'd3, 8'hFF); rd_chk("R3", 2'd3, 8'h93);
        wr_reg(2'd3, 8'h6C); rd_chk("R3", 2'd3, 8'h00);
        wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'hFF);
        #0.5; chk("R6", "pu all inputs high", pad_pu, 8'hFF);
        wr_reg(2'd3, 8'h10);
        #0.5; chk("R3", "pu off via bit 4", pad_pu, 8'h00);
        wr_reg(2'd3, 8'h00);

        // R4: pin address ignores writes
        wr_reg(2'd0, 8'h5A); wr_reg(2'd1, 8'hC3);
        wr_reg(2'd2, 8'hFF);
        rd_chk("R4", 2'd0, 8'h5A);
        rd_chk("R4", 2'd1, 8'hC3);
        rd_chk("R4", 2'd3, 8'h00);
        rd_chk("R4", 2'd2, 8'h00);

        // R11: two-edge input latency, also under takeover
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            xm_en = (k == 1); xm_ale = (k == 1);
            pad_in = (k == 0) ? 8'h96 : 8'h2D;
            reg_addr = 2'd2;
            @(negedge clk); #0.5;
            chk("R11", "one edge", xm_rdata, (k == 0) ? 8'h00 : 8'h96);
            @(negedge clk); #0.5;
            chk("R11", "two edges", xm_rdata, pad_in);
            chk("R11", "pin register", reg_rdata, pad_in);
        end
        xm_en = 1'b0; xm_ale = 1'b0;

        // R5..R10: sweep of patterns and mode/strobe combinations
        for (int p = 0; p < 8; p++) begin
            dv = 8'(p * 8'h29) ^ 8'hC3;
            pv = 8'(p * 8'h57 + 8'h11);
            wr_reg(2'd0, dv);
            wr_reg(2'd1, pv);
            for (int c = 0; c < 16; c++) begin
                {pud, en, w, ale} = 4'(c);
                wr_reg(2'd3, pud ? 8'h10 : 8'h00);
                av = 8'(p * 8'h1D + c);
                wv = ~av ^ 8'(c * 8'h33);
                xm_en = en; xm_wr = w; xm_ale = ale; xm_addr = av; xm_wdata = wv;
                #0.5;
                e_oe  = en ? {8{w | ale}} : dv;
                e_out = en ? ((av & {8{ale}}) | (wv & {8{w}})) : pv;
                e_pu  = pud ? 8'h00 : (en ? ((w | ale) ? 8'h00 : pv) : (~dv & pv));
                chk(en ? "R8" : "R5", "oe", pad_oe, e_oe);
                chk(en ? "R9" : "R5", "out", pad_out, e_out);
                chk(pud ? "R7" : (en ? "R10" : "R6"), "pu", pad_pu, e_pu);
                chk("R10", "pu and oe disjoint", pad_pu & pad_oe, 8'h00);
            end
            xm_en = 1'b0; xm_wr = 1'b0; xm_ale = 1'b0;
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule